// File: doc/BRIEF.md
# Quarter-Rate Tone Notch Calibration Sequencer

This controller trims a continuous-time bandpass noise-shaping converter loop whose resonator should sit at one quarter of the sample rate. A calibration tone is injected at that frequency in front of the quantizer. The block watches the signed multi-bit output stream and measures how much of the tone survives. It then adjusts three trim codes so that the surviving power is as small as possible. The codes are a resonator capacitor-bank code, a feedback DAC gain code and a loop delay code.

Calibration runs only when requested, for example at power-up or while the receiver is idle. Each measurement demodulates the stream against the quarter-rate cosine and sine patterns over a window of 2^N valid samples. The block forms the in-phase and quadrature sums and uses their squared magnitude as the power figure. Each code is searched with a one-step hill climb. The capacitor code is searched to convergence first, then the DAC gain code, then the delay code. After every change the block discards a programmable number of samples while the analog loop settles. A measurement budget guards against a search that never ends.

Top module: `notch_trim_seq`

## Requirements
- R1: After reset all three codes are 0, busy, done and err are 0, and tone_pwr is 0.
- R2: A start pulse is accepted only while busy is 0. On the following cycle busy is 1 and each code equals its maximum shifted right by one bit. A start pulse while busy is 1 has no effect.
- R3: The power figure is I*I+Q*Q, taken over a window of 2^win_log2 valid samples (win_log2 is clamped to WMAX and must be at least 2). I adds the samples at window positions 0 mod 4 and subtracts those at 2 mod 4. Q adds the samples at 1 mod 4 and subtracts those at 3 mod 4. A DC offset and a half-rate component therefore cancel exactly.
- R4: After start and after every trim step, the first settle_len valid samples are discarded. The next measurement window opens only after them.
- R5: Each code is searched in steps of one code, upward first. A search reverses at most once, and only when the first step makes the power rise. A search stops when the power rises in both directions or when a limit blocks the next step. It leaves the code at the lowest-power setting seen. For a response with a single minimum, the final codes equal that minimum.
- R6: A code never leaves the range 0 to its configured maximum. Reaching a limit ends that code's search.
- R7: The capacitor code converges before the gain code moves, and the gain code converges before the delay code moves. At most one code changes in any cycle of a run.
- R8: When the delay search converges, done rises and busy falls. tone_pwr then holds the power measured at the final codes, and all codes stay fixed until the next start.
- R9: If max_meas measurements have completed and the sequence is not finished, err rises and busy falls. The codes and err then hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Calibration request pulse |
| smp_valid | input | 1 | Sample strobe |
| smp | input | SW | Signed modulator output sample |
| win_log2 | input | clog2(WMAX+1) | log2 of the measurement window length |
| settle_len | input | SCW | Valid samples discarded after each change |
| max_meas | input | MW | Measurement budget |
| cap_max | input | CW | Capacitor code upper limit |
| gain_max | input | CW | DAC gain code upper limit |
| dly_max | input | CW | Loop delay code upper limit |
| cap_code | output | CW | Resonator capacitor-bank trim |
| gain_code | output | CW | Feedback DAC gain trim |
| dly_code | output | CW | Loop delay trim |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Calibration completed |
| err | output | 1 | Calibration aborted on budget |
| tone_pwr | output | 2*(SW+WMAX) | Last measured tone power |

## Verification
Some properties can be checked on every cycle: the status flags exclude one another, codes stay inside their limits during a run, no two codes move in the same cycle, and codes and flags hold after completion or abort. Other behaviour needs whole scenarios. The bench models a loop whose tone amplitude grows with each code's distance from a hidden optimum. It drives large disturbances during the settling interval, so any leak of those samples into a window corrupts the search. The scenarios then show that the search lands on the optimum, that the power figure rejects DC and half-rate content, and that the capacitor, gain and delay searches run in that order.

// File: rtl/notch_trim_seq.sv
module notch_trim_seq #(
  parameter int SW   = 8,
  parameter int CW   = 6,
  parameter int WMAX = 10,
  parameter int SCW  = 16,
  parameter int MW   = 16,
  localparam int LW  = $clog2(WMAX + 1),
  localparam int AW  = SW + WMAX,
  localparam int PW  = 2 * AW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 smp_valid,
  input  logic signed [SW-1:0] smp,
  input  logic [LW-1:0]        win_log2,
  input  logic [SCW-1:0]       settle_len,
  input  logic [MW-1:0]        max_meas,
  input  logic [CW-1:0]        cap_max,
  input  logic [CW-1:0]        gain_max,
  input  logic [CW-1:0]        dly_max,
  output logic [CW-1:0]        cap_code,
  output logic [CW-1:0]        gain_code,
  output logic [CW-1:0]        dly_code,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic [PW-1:0]        tone_pwr
);

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_ACC, S_EVAL, S_DONE, S_ERR} st_t;

  st_t                 st;
  logic [1:0]          ph;
  logic                have_ref, dir_up, rev;
  logic [PW-1:0]       ref_p;
  logic [SCW-1:0]      scnt;
  logic [MW-1:0]       mcnt;
  logic [WMAX-1:0]     sidx;
  logic signed [AW-1:0] acc_i, acc_q;

  logic [LW-1:0]       nlog;
  logic [WMAX:0]       span, last_w;
  logic signed [AW-1:0] sx;
  logic signed [PW-1:0] sq_i, sq_q;
  logic [PW-1:0]       meas;

  assign nlog   = (win_log2 > LW'(WMAX)) ? LW'(WMAX) : win_log2;
  assign span   = (WMAX+1)'(1) << nlog;
  assign last_w = span - (WMAX+1)'(1);
  assign sx     = AW'(smp);
  assign sq_i   = PW'(acc_i) * PW'(acc_i);
  assign sq_q   = PW'(acc_q) * PW'(acc_q);
  assign meas   = $unsigned(sq_i) + $unsigned(sq_q);

  logic [CW-1:0] cur, lim, back, fwd, nx_code;
  logic          up_ok, dn_ok, bup_ok, bdn_ok, fwd_ok;
  logic          nx_dir, nx_rev, conv, fin, abort;
  logic [PW-1:0] nx_ref;

  assign cur    = (ph == 2'd0) ? cap_code : (ph == 2'd1) ? gain_code : dly_code;
  assign lim    = (ph == 2'd0) ? cap_max  : (ph == 2'd1) ? gain_max  : dly_max;
  assign up_ok  = cur < lim;
  assign dn_ok  = cur != '0;
  assign fwd_ok = dir_up ? up_ok : dn_ok;
  assign fwd    = dir_up ? cur + CW'(1) : cur - CW'(1);
  assign back   = dir_up ? cur - CW'(1) : cur + CW'(1);
  assign bup_ok = back < lim;
  assign bdn_ok = back != '0;

  always_comb begin
    nx_code = cur;
    nx_dir  = dir_up;
    nx_rev  = rev;
    nx_ref  = ref_p;
    conv    = 1'b0;
    if (!have_ref) begin
      nx_ref = meas;
      if (fwd_ok) nx_code = fwd;
      else if (dir_up ? dn_ok : up_ok) begin
        nx_dir  = !dir_up;
        nx_rev  = 1'b1;
        nx_code = back;
      end else conv = 1'b1;
    end else if (meas < ref_p) begin
      nx_ref = meas;
      nx_rev = 1'b1;
      if (fwd_ok) nx_code = fwd;
      else conv = 1'b1;
    end else begin
      nx_code = back;
      if (rev) conv = 1'b1;
      else begin
        nx_dir = !dir_up;
        nx_rev = 1'b1;
        if (dir_up ? bdn_ok : bup_ok) nx_code = dir_up ? back - CW'(1) : back + CW'(1);
        else conv = 1'b1;
      end
    end
  end

  assign fin   = conv && (ph == 2'd2);
  assign abort = !fin && ((mcnt + MW'(1)) >= max_meas);

  assign busy = (st == S_SETTLE) || (st == S_ACC) || (st == S_EVAL);
  assign done = st == S_DONE;
  assign err  = st == S_ERR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ph        <= 2'd0;
      have_ref  <= 1'b0;
      dir_up    <= 1'b1;
      rev       <= 1'b0;
      ref_p     <= '0;
      scnt      <= '0;
      mcnt      <= '0;
      sidx      <= '0;
      acc_i     <= '0;
      acc_q     <= '0;
      cap_code  <= '0;
      gain_code <= '0;
      dly_code  <= '0;
      tone_pwr  <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE, S_ERR: if (start) begin
          cap_code  <= cap_max >> 1;
          gain_code <= gain_max >> 1;
          dly_code  <= dly_max >> 1;
          ph        <= 2'd0;
          have_ref  <= 1'b0;
          dir_up    <= 1'b1;
          rev       <= 1'b0;
          mcnt      <= '0;
          scnt      <= '0;
          st        <= S_SETTLE;
        end
        S_SETTLE: begin
          if (scnt == settle_len) begin
            acc_i <= '0;
            acc_q <= '0;
            sidx  <= '0;
            st    <= S_ACC;
          end else if (smp_valid) scnt <= scnt + SCW'(1);
        end
        S_ACC: if (smp_valid) begin
          case (sidx[1:0])
            2'd0:    acc_i <= acc_i + sx;
            2'd1:    acc_q <= acc_q + sx;
            2'd2:    acc_i <= acc_i - sx;
            default: acc_q <= acc_q - sx;
          endcase
          sidx <= sidx + WMAX'(1);
          if ({1'b0, sidx} == last_w) st <= S_EVAL;
        end
        S_EVAL: begin
          mcnt     <= mcnt + MW'(1);
          tone_pwr <= meas;
          scnt     <= '0;
          if (!abort) begin
            case (ph)
              2'd0:    cap_code  <= nx_code;
              2'd1:    gain_code <= nx_code;
              default: dly_code  <= nx_code;
            endcase
          end
          if (fin) begin
            tone_pwr <= nx_ref;
            st       <= S_DONE;
          end else if (abort) begin
            st <= S_ERR;
          end else if (conv) begin
            ph       <= ph + 2'd1;
            have_ref <= 1'b0;
            dir_up   <= 1'b1;
            rev      <= 1'b0;
            st       <= S_SETTLE;
          end else begin
            have_ref <= 1'b1;
            dir_up   <= nx_dir;
            rev      <= nx_rev;
            ref_p    <= nx_ref;
            st       <= S_SETTLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/notch_trim_seq_chk.sv
module notch_trim_seq_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [CW-1:0] cap_code,
  input logic [CW-1:0] gain_code,
  input logic [CW-1:0] dly_code,
  input logic [CW-1:0] cap_max,
  input logic [CW-1:0] gain_max,
  input logic [CW-1:0] dly_max
);

  // R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done, err}));

  // R6
  code_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cap_code <= cap_max) && (gain_code <= gain_max) && (dly_code <= dly_max));

  // R7
  single_code_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $countones({!$stable(cap_code), !$stable(gain_code), !$stable(dly_code)}) <= 1);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done && $stable(cap_code) && $stable(gain_code) && $stable(dly_code));

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err && $stable(cap_code) && $stable(gain_code) && $stable(dly_code));

endmodule

bind notch_trim_seq notch_trim_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
  .cap_code(cap_code), .gain_code(gain_code), .dly_code(dly_code),
  .cap_max(cap_max), .gain_max(gain_max), .dly_max(dly_max)
);

// File: tb/notch_trim_seq_tb.sv
module notch_trim_seq_tb;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              smp_valid = 1'b0;
  logic signed [7:0] smp = '0;
  logic [3:0]        win_log2 = 4'd4;
  logic [15:0]       settle_len = 16'd0;
  logic [15:0]       max_meas = 16'd200;
  logic [5:0]        cap_max = 6'd15, gain_max = 6'd15, dly_max = 6'd15;
  logic [5:0]        cap_code, gain_code, dly_code;
  logic              busy, done, err;
  logic [35:0]       tone_pwr;

  notch_trim_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid), .smp(smp),
    .win_log2(win_log2), .settle_len(settle_len), .max_meas(max_meas),
    .cap_max(cap_max), .gain_max(gain_max), .dly_max(dly_max),
    .cap_code(cap_code), .gain_code(gain_code), .dly_code(dly_code),
    .busy(busy), .done(done), .err(err), .tone_pwr(tone_pwr)
  );

  always #2 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  int opt_c = 0, opt_g = 0, opt_d = 0, dc = 0, hf = 0;
  int ord_viol = 0, lim_viol = 0;

  function automatic int absi(input int x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic int amp_of(input int c, input int g, input int d);
    return 4 + absi(c - opt_c) + absi(g - opt_g) + absi(d - opt_d);
  endfunction

  function automatic longint exp_pwr(input int n, input int a);
    return longint'(a) * longint'(a) * (longint'(1) << (2 * (n - 1)));
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // loop model: tone amplitude set by code distance; disturbance during settling
  int m = 0, scnt_b = 0;
  logic [5:0] lc = '0, lg = '0, ld = '0;
  always @(negedge clk) begin
    int v, a;
    bit launch;
    launch = start && !busy;
    if (launch || cap_code != lc || gain_code != lg || dly_code != ld) scnt_b = 0;
    lc = cap_code; lg = gain_code; ld = dly_code;
    smp_valid = ($urandom % 4) != 0;
    v = 0;
    if (smp_valid) begin
      if (!launch && scnt_b < int'(settle_len))
        v = (m % 4 == 0) ? 100 : (m % 4 == 2) ? -100 : 0;
      else begin
        a = amp_of(int'(cap_code), int'(gain_code), int'(dly_code));
        v = ((m % 4 == 0) ? a : (m % 4 == 2) ? -a : 0) + dc + ((m % 2 == 0) ? hf : -hf);
      end
      if (!launch) scnt_b++;
      m++;
    end
    smp = 8'(v);
  end

  // order and range monitor
  int stage = 0;
  logic pbusy = 1'b0;
  logic [5:0] pc = '0, pg = '0, pd = '0;
  always @(negedge clk) begin
    if (busy && !pbusy) stage = 0;
    if (busy && pbusy) begin
      if (dly_code != pd) stage = 2;
      if (gain_code != pg) begin
        if (stage > 1) ord_viol++;
        if (stage < 1) stage = 1;
      end
      if (cap_code != pc && stage > 0) ord_viol++;
    end
    if (busy && (cap_code > cap_max || gain_code > gain_max || dly_code > dly_max)) lim_viol++;
    pbusy = busy; pc = cap_code; pg = gain_code; pd = dly_code;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      tests++; fails++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic run_cal(input int cm, input int gm, input int dm,
                         input int oc, input int og, input int od,
                         input int n, input int stl, input int mm,
                         input bit exp_err, input bit restart);
    int k;
    logic [5:0] hc, hg, hd;
    @(posedge clk); #1;
    cap_max = 6'(cm); gain_max = 6'(gm); dly_max = 6'(dm);
    opt_c = oc; opt_g = og; opt_d = od;
    win_log2 = 4'(n); settle_len = 16'(stl); max_meas = 16'(mm);
    ord_viol = 0; lim_viol = 0;
    pulse_start();
    @(negedge clk);
    chk(busy && cap_code == 6'(cm/2) && gain_code == 6'(gm/2) && dly_code == 6'(dm/2),
        "R2 start loads mid codes", longint'({busy, cap_code, gain_code, dly_code}),
        longint'({1'b1, 6'(cm/2), 6'(gm/2), 6'(dm/2)}));
    if (restart) begin
      repeat (60) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      @(negedge clk);
      chk(busy, "R2 start ignored while busy", longint'(busy), 1);
    end
    k = 0;
    while (!(done || err) && k < 40000) begin @(negedge clk); k++; end
    if (!exp_err) begin
      chk(done && !err && !busy, "R8 done raised", longint'({done, err, busy}), 4);
      chk(cap_code == 6'(oc), "R4/R5 cap code at optimum", longint'(cap_code), oc);
      chk(gain_code == 6'(og), "R4/R5 gain code at optimum", longint'(gain_code), og);
      chk(dly_code == 6'(od), "R4/R5 delay code at optimum", longint'(dly_code), od);
      chk(longint'(tone_pwr) == exp_pwr(n, 4), "R3/R8 final power", longint'(tone_pwr), exp_pwr(n, 4));
      chk(ord_viol == 0, "R7 search order", ord_viol, 0);
      chk(lim_viol == 0, "R6 codes in range", lim_viol, 0);
      hc = cap_code; hg = gain_code; hd = dly_code;
      repeat (40) @(negedge clk);
      chk(done && cap_code == hc && gain_code == hg && dly_code == hd, "R8 codes held after done",
          longint'({done, cap_code, gain_code, dly_code}), longint'({1'b1, hc, hg, hd}));
    end else begin
      chk(err && !done && !busy, "R9 abort flag", longint'({err, done, busy}), 4);
      if (mm == 1)
        chk(longint'(tone_pwr) == exp_pwr(n, amp_of(cm/2, gm/2, dm/2)), "R3 power at mid codes",
            longint'(tone_pwr), exp_pwr(n, amp_of(cm/2, gm/2, dm/2)));
      hc = cap_code; hg = gain_code; hd = dly_code;
      repeat (30) @(negedge clk);
      chk(err && cap_code == hc && gain_code == hg && dly_code == hd, "R9 codes held after abort",
          longint'({err, cap_code, gain_code, dly_code}), longint'({1'b1, hc, hg, hd}));
    end
  endtask

  initial begin
    int s;
    s = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cap_code == 0 && gain_code == 0 && dly_code == 0 && !busy && !done && !err && tone_pwr == 0,
        "R1 reset state", longint'({cap_code, gain_code, dly_code, busy, done, err}), 0);
    #1 rst_n = 1'b1;

    dc = 10; hf = -5;
    run_cal(15, 15, 15, 3, 12, 7, 4, 8, 200, 1'b0, 1'b0);
    dc = -20; hf = 20;
    run_cal(15, 15, 15, 0, 15, 0, 4, 6, 200, 1'b0, 1'b0);   // R6 optimum at both limits
    dc = 0; hf = 0;
    run_cal(9, 0, 4, 9, 0, 1, 3, 4, 200, 1'b0, 1'b0);       // R6 zero-range gain code
    dc = 7; hf = 3;
    run_cal(12, 10, 8, 2, 9, 5, 3, 0, 200, 1'b0, 1'b0);     // R4 no settling interval
    run_cal(15, 15, 15, 11, 4, 13, 4, 5, 200, 1'b0, 1'b1);  // R2 start while busy
    for (int i = 0; i < 5; i++) begin
      int cm, gm, dm;
      cm = 1 + int'($urandom % 15); gm = 1 + int'($urandom % 15); dm = 1 + int'($urandom % 15);
      dc = int'($urandom % 41) - 20; hf = int'($urandom % 41) - 20;
      run_cal(cm, gm, dm, int'($urandom % (cm + 1)), int'($urandom % (gm + 1)),
              int'($urandom % (dm + 1)), 2 + int'($urandom % 4), int'($urandom % 13),
              200, 1'b0, 1'b0);
    end
    dc = 15; hf = -12;
    run_cal(15, 15, 15, 3, 12, 7, 5, 5, 1, 1'b1, 1'b0);     // R9 budget of one
    run_cal(15, 15, 15, 0, 0, 0, 4, 3, 4, 1'b1, 1'b0);      // R9 budget of four
    run_cal(15, 15, 15, 6, 8, 2, 4, 3, 200, 1'b0, 1'b0);    // R2 restart after abort

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule